// File: doc/BRIEF.md
# Video Timing Reference Word Normalizer

This block sits on a 10-bit parallel video data path in the parallel clock domain. It watches each word for the reserved code values that mark timing reference (sync) words. A word is reserved when its upper eight bits are all zeros or all ones. When a word is reserved, the block rewrites its two least significant bits to match the upper bits. An 8-bit source leaves its low two bits undefined, so after this step it still produces legal 10-bit reserved words.

A bypass input turns the rewrite off for payloads that do not follow the standard. Words then pass through untouched. The block has two outputs: the normalized word and a one-cycle flag that marks each reserved word it has seen.

The input is captured on one clock edge. The result appears on the next edge, so the total latency is two cycles.

Top module: `trs_normalizer`

## Requirements
- R1: While `rst` is high at a rising edge, `word_o` becomes 0x000 and `resv_o` becomes 0 at that edge.
- R2: `word_i` is registered on a rising edge of `clk`. The matching `word_o` and `resv_o` appear after the following rising edge, two cycles after the word is presented.
- R3: If the captured word has bits 9:2 all zero and `bypass_i` is low, `word_o` is 0x000, whatever bits 1:0 of the input were.
- R4: If the captured word has bits 9:2 all one and `bypass_i` is low, `word_o` is 0x3FF, whatever bits 1:0 of the input were.
- R5: When `bypass_i` is high in the cycle a word is captured, `word_o` equals that word bit for bit and `resv_o` is 0.
- R6: A word whose bits 9:2 are not all equal passes to `word_o` bit for bit, whatever the level of `bypass_i`, and `resv_o` is 0.
- R7: `resv_o` is 1 for exactly the cycle in which a normalized reserved word (0x000 or 0x3FF from R3 or R4) is on `word_o`, and it is 0 otherwise.
- R8: Bits 9:2 of `word_o` always equal bits 9:2 of the captured input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bypass_i | input | 1 | High turns off reserved-word detection and rewriting |
| word_i | input | 10 | Parallel video word |
| word_o | output | 10 | Normalized video word |
| resv_o | output | 1 | High for one cycle with each normalized reserved word |

## Verification
Every result is due two rising edges after its stimulus: one edge captures the word and the bypass level, and the next edge registers the output and the flag. The bench drives a vector on the falling edge and waits through two rising edges. It samples on the next falling edge and compares against values worked out from the requirements. The flag's one-cycle width is checked by feeding a reserved word followed by a plain word and sampling the output on two consecutive cycles.

// File: rtl/trs_normalizer.sv
module trs_normalizer #(
  parameter int W = 10,
  parameter int LSBS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bypass_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o,
  output logic         resv_o
);
  localparam int HI = W - LSBS;

  logic [W-1:0] cap_q;
  logic         byp_q;
  logic         lo_hit, hi_hit, hit;

  assign lo_hit = (cap_q[W-1:LSBS] == '0);
  assign hi_hit = (cap_q[W-1:LSBS] == {HI{1'b1}});
  assign hit    = !byp_q && (lo_hit || hi_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      byp_q <= 1'b1;
    end else begin
      cap_q <= word_i;
      byp_q <= bypass_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      resv_o <= 1'b0;
    end else begin
      word_o <= hit ? {cap_q[W-1:LSBS], {LSBS{hi_hit}}} : cap_q;
      resv_o <= hit;
    end
  end
endmodule

module trs_normalizer_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         bypass_i,
  input logic [W-1:0] word_i,
  input logic [W-1:0] word_o,
  input logic         resv_o
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_ff @(posedge clk) begin
    if ($past(rst)) begin
      assert_reset_clear_R1: assert (word_o == '0 && !resv_o);
    end
  end

  assert_flag_value_R7: assert property (@(posedge clk) disable iff (rst)
    resv_o |-> (word_o == '0 || word_o == '1));

  assert_bypass_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(bypass_i, 2)) |-> (word_o == $past(word_i, 2) && !resv_o));

  assert_upper_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (word_o[W-1:2] == $past(word_i[W-1:2], 2)));

  assert_mixed_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(word_i[W-1:2], 2) != '0 && $past(word_i[W-1:2], 2) != '1)
      |-> (word_o == $past(word_i, 2) && !resv_o));

  assert_force_R3_R4: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && !$past(bypass_i, 2) &&
     ($past(word_i[W-1:2], 2) == '0 || $past(word_i[W-1:2], 2) == '1))
      |-> (resv_o && word_o == {W{word_o[W-1]}}));
endmodule

bind trs_normalizer trs_normalizer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bypass_i(bypass_i),
  .word_i(word_i), .word_o(word_o), .resv_o(resv_o)
);

// File: tb/trs_normalizer_tb.sv
module trs_normalizer_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       bypass_i = 0;
  logic [9:0] word_i = '0;
  logic [9:0] word_o;
  logic       resv_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trs_normalizer u_dut (.clk(clk), .rst(rst), .bypass_i(bypass_i),
    .word_i(word_i), .word_o(word_o), .resv_o(resv_o));

  // {bypass, input, expected word, expected flag}
  localparam int N = 14;
  localparam logic [21:0] VEC [N] = '{
    {1'b0, 10'h000, 10'h000, 1'b1},   // R3
    {1'b0, 10'h003, 10'h000, 1'b1},   // R3
    {1'b0, 10'h001, 10'h000, 1'b1},   // R3
    {1'b0, 10'h3FC, 10'h3FF, 1'b1},   // R4
    {1'b0, 10'h3FE, 10'h3FF, 1'b1},   // R4
    {1'b0, 10'h3FF, 10'h3FF, 1'b1},   // R4
    {1'b1, 10'h002, 10'h002, 1'b0},   // R5
    {1'b1, 10'h3FD, 10'h3FD, 1'b0},   // R5
    {1'b0, 10'h004, 10'h004, 1'b0},   // R6
    {1'b0, 10'h3FB, 10'h3FB, 1'b0},   // R6
    {1'b1, 10'h200, 10'h200, 1'b0},   // R6
    {1'b0, 10'h155, 10'h155, 1'b0},   // R6 R8
    {1'b0, 10'h2AA, 10'h2AA, 1'b0},   // R6 R8
    {1'b1, 10'h1FF, 10'h1FF, 1'b0}    // R6
  };

  task automatic check(input string req, input logic [9:0] ew, input logic ef);
    checks++;
    if (word_o !== ew || resv_o !== ef) begin
      fails++;
      $display("FAIL %s: got word=%h flag=%b, expected word=%h flag=%b",
               req, word_o, resv_o, ew, ef);
    end
  endtask

  task automatic apply(input logic b, input logic [9:0] w);
    @(negedge clk); bypass_i = b; word_i = w;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 10'h000, 1'b0);
    rst = 0;
    foreach (VEC[i]) begin
      apply(VEC[i][21], VEC[i][20:11]);
      check("R2 R3 R4 R5 R6 R8", VEC[i][10:1], VEC[i][0]);
    end
    // R7: flag for one cycle only
    @(negedge clk); bypass_i = 0; word_i = 10'h3FD;
    @(negedge clk); word_i = 10'h123;
    @(negedge clk); check("R7", 10'h3FF, 1'b1);
    @(negedge clk); check("R7", 10'h123, 1'b0);
    // R2: latency exactly two edges
    @(negedge clk); word_i = 10'h0F0;
    @(posedge clk); @(negedge clk);
    check("R2", 10'h123, 1'b0);
    @(negedge clk); check("R2", 10'h0F0, 1'b0);
    // R1: reset while data is flowing
    word_i = 10'h3FF;
    @(negedge clk); rst = 1;
    @(negedge clk); check("R1", 10'h000, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); fails++; checks++;
        $display("FAIL watchdog: got timeout, expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule